// File: doc/BRIEF.md
# ADC Input Multiplexer Sequencer

This block shares one delta-sigma converter among eight analog sources: six main current inputs, a temperature sensor and a neutral-current input. It walks a list of multiplexer states once per cycle and times every conversion in periods of a 32768 Hz reference. For each conversion it drives the channel select, a conversion-start pulse and, when the conversion ends, a store strobe with the word address of the result. The converter and the decimation filter are outside the block. Their timing is represented only by the fixed number of reference periods that each conversion takes.

A regular cycle samples the six current inputs. An alternate cycle, which must be requested, replaces the first and third samples with the temperature and neutral readings. Every cycle ends with one settle period in which no conversion runs. A downstream computation engine receives a pulse whenever state 0 begins. A chopper polarity output is held low or held high, or it flips once per cycle.

The block runs on a fast system clock. `tick_i` is a one-clock pulse once per reference period. Every output changes only on the clock edge that samples a tick.

Top module: `adc_mux_seq`

## Requirements
- R1: In a regular cycle, states 0 to 5 select channel codes 0 to 5 in that order. Codes 0 to 5 are the current inputs I0 to I5.
- R2: In an alternate cycle, state 0 selects code 6 (temperature) and state 2 selects code 7 (neutral). The other states keep their regular codes.
- R3: `nsel_i` values 0, 1, 2 and 3 give 2, 3, 4 and 6 states per cycle.
- R4: A conversion lasts 2 ticks when `flen_i` is 0 and 3 ticks when it is 1. `conv_start_o` pulses for one clock on the tick that begins a conversion. `store_we_o` pulses for one clock on the tick that ends it. Both pulses occur only after a tick.
- R5: `store_addr_o` equals ADDR_BASE plus the channel code of the conversion that just ended. The codes are 0 to 5 for I0 to I5, 6 for temperature and 7 for neutral.
- R6: `eng_start_o` pulses, together with `conv_start_o`, exactly when state 0 begins.
- R7: Chop mode 0 drives `chop_o` low and mode 1 drives it high. Modes 2 and 3 invert it at every cycle boundary. `chop_o` changes only at a cycle boundary.
- R8: Each cycle ends with one settle tick in which no conversion starts. A cycle therefore lasts states x length + 1 ticks, which is 13 ticks for 6 states of 2 ticks.
- R9: A one-clock pulse on `alt_req_i` at any time is held until the next cycle boundary. The cycle that follows is an alternate cycle, and the cycle after it is regular unless another request arrives.
- R10: `nsel_i`, `flen_i` and `chop_mode_i` take effect only at a cycle boundary.
- R11: After reset all pulses are low, `chop_o` is low and the sequence sits in the settle slot, so the first tick begins state 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-clock pulse per 32768 Hz period |
| alt_req_i | input | 1 | Request for one alternate cycle |
| nsel_i | input | 2 | States-per-cycle selection |
| flen_i | input | 1 | Filter length: 0 gives 2 ticks, 1 gives 3 ticks |
| chop_mode_i | input | 2 | Chopper mode |
| mux_sel_o | output | 3 | Selected channel code |
| conv_start_o | output | 1 | Conversion start pulse |
| store_we_o | output | 1 | Result store strobe |
| store_addr_o | output | ADDR_W | Result word address |
| eng_start_o | output | 1 | Engine start pulse at state 0 |
| chop_o | output | 1 | Chopper polarity |

## Verification
The assertions check several rules on every cycle. Pulses appear only after a tick. The state and sub-period counters stay inside the current configuration. No conversion starts in the settle slot. The engine pulse coincides with a start on code 0 or code 6. Chop polarity, the alternate flag and the latched configuration change only at a boundary. Other behaviour can only be shown by the bench's sweeps. These include the exact orderings, the addresses, the cycle length for each configuration, the one-cycle life of an alternate request and the deferral of mid-cycle configuration changes. The bench compares every tick against an arithmetic model of the cycle position.

// File: rtl/adc_mux_pkg.sv
package adc_mux_pkg;
  localparam int CH_W = 3;
  localparam logic [CH_W-1:0] CH_TEMP = 3'd6;
  localparam logic [CH_W-1:0] CH_NEUT = 3'd7;

  localparam logic [1:0] CHOP_LOW  = 2'd0;
  localparam logic [1:0] CHOP_HIGH = 2'd1;

  // number of multiplexer states for a 2-bit selection
  function automatic logic [2:0] states_of(input logic [1:0] sel);
    case (sel)
      2'd0:    return 3'd2;
      2'd1:    return 3'd3;
      2'd2:    return 3'd4;
      default: return 3'd6;
    endcase
  endfunction

  // reference periods per conversion
  function automatic logic [1:0] len_of(input logic flen);
    return flen ? 2'd3 : 2'd2;
  endfunction

  // channel code for a state in a regular or alternate cycle
  function automatic logic [CH_W-1:0] chan_of(input logic [2:0] st, input logic alt);
    if (alt && st == 3'd0) return CH_TEMP;
    if (alt && st == 3'd2) return CH_NEUT;
    return st;
  endfunction

  // next chopper polarity at a boundary
  function automatic logic chop_next(input logic [1:0] mode, input logic cur);
    case (mode)
      CHOP_LOW:  return 1'b0;
      CHOP_HIGH: return 1'b1;
      default:   return ~cur;
    endcase
  endfunction
endpackage

// File: rtl/adc_mux_pos.sv
module adc_mux_pos (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic [2:0] n_states,
  input  logic [1:0] c_len,
  output logic [2:0] state_o,
  output logic       idle_o,
  output logic       bnd_o,
  output logic       conv_begin_o,
  output logic       conv_end_o,
  output logic [2:0] next_state_o
);
  logic [2:0] state_q;
  logic [1:0] sub_q;
  logic       idle_q;
  logic       last_sub, last_st;

  always_comb begin
    last_sub     = (sub_q == c_len - 2'd1);
    last_st      = (state_q == n_states - 3'd1);
    bnd_o        = tick_i && idle_q;
    conv_end_o   = tick_i && !idle_q && last_sub;
    conv_begin_o = bnd_o || (conv_end_o && !last_st);
    next_state_o = bnd_o ? 3'd0 : state_q + 3'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      sub_q   <= '0;
      idle_q  <= 1'b1;
    end else if (tick_i) begin
      if (idle_q) begin
        idle_q  <= 1'b0;
        state_q <= '0;
        sub_q   <= '0;
      end else if (last_sub) begin
        sub_q <= '0;
        if (last_st) idle_q <= 1'b1;
        else         state_q <= state_q + 3'd1;
      end else begin
        sub_q <= sub_q + 2'd1;
      end
    end
  end

  assign state_o = state_q;
  assign idle_o  = idle_q;

  assert_sub_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_q |-> sub_q < c_len);
  assert_state_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_q |-> state_q < n_states);
  assert_idle_one_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_q && tick_i) |=> !idle_q);
endmodule

// File: rtl/adc_mux_cfg.sv
module adc_mux_cfg
  import adc_mux_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bnd_i,
  input  logic       alt_req_i,
  input  logic [1:0] nsel_i,
  input  logic       flen_i,
  input  logic [1:0] chop_mode_i,
  output logic [2:0] n_states,
  output logic [1:0] c_len,
  output logic       alt_act,
  output logic       alt_now,
  output logic       chop_o
);
  logic pend_q;

  assign alt_now = bnd_i ? (pend_q || alt_req_i) : alt_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_states <= 3'd6;
      c_len    <= 2'd2;
      alt_act  <= 1'b0;
      pend_q   <= 1'b0;
      chop_o   <= 1'b0;
    end else if (bnd_i) begin
      n_states <= states_of(nsel_i);
      c_len    <= len_of(flen_i);
      alt_act  <= pend_q || alt_req_i;
      pend_q   <= 1'b0;
      chop_o   <= chop_next(chop_mode_i, chop_o);
    end else if (alt_req_i) begin
      pend_q <= 1'b1;
    end
  end

  assert_chop_at_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chop_o) |-> $past(bnd_i));
  assert_alt_at_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(alt_act) |-> $past(bnd_i));
  assert_cfg_at_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(n_states) || !$stable(c_len)) |-> $past(bnd_i));
  assert_pend_consumed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bnd_i |=> !pend_q);
endmodule

// File: rtl/adc_mux_seq.sv
module adc_mux_seq
  import adc_mux_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int ADDR_BASE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              alt_req_i,
  input  logic [1:0]        nsel_i,
  input  logic              flen_i,
  input  logic [1:0]        chop_mode_i,
  output logic [CH_W-1:0]   mux_sel_o,
  output logic              conv_start_o,
  output logic              store_we_o,
  output logic [ADDR_W-1:0] store_addr_o,
  output logic              eng_start_o,
  output logic              chop_o
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(ADDR_BASE);

  logic [2:0] n_states, state, next_state;
  logic [1:0] c_len;
  logic       idle, bnd, conv_begin, conv_end;
  logic       alt_act, alt_now;

  adc_mux_pos u_pos (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .n_states(n_states), .c_len(c_len),
    .state_o(state), .idle_o(idle), .bnd_o(bnd),
    .conv_begin_o(conv_begin), .conv_end_o(conv_end),
    .next_state_o(next_state)
  );

  adc_mux_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .bnd_i(bnd), .alt_req_i(alt_req_i),
    .nsel_i(nsel_i), .flen_i(flen_i), .chop_mode_i(chop_mode_i),
    .n_states(n_states), .c_len(c_len), .alt_act(alt_act),
    .alt_now(alt_now), .chop_o(chop_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mux_sel_o    <= '0;
      conv_start_o <= 1'b0;
      eng_start_o  <= 1'b0;
      store_we_o   <= 1'b0;
      store_addr_o <= '0;
    end else begin
      conv_start_o <= conv_begin;
      eng_start_o  <= conv_begin && (next_state == 3'd0);
      store_we_o   <= conv_end;
      if (conv_begin) mux_sel_o <= chan_of(next_state, alt_now);
      if (conv_end)   store_addr_o <= BASE + ADDR_W'(chan_of(state, alt_act));
    end
  end

  assert_start_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start_o || store_we_o) |-> $past(tick_i));
  assert_engine_with_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start_o |-> (conv_start_o && (mux_sel_o == 3'd0 || mux_sel_o == CH_TEMP)));
  assert_alt_first_temp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start_o && alt_act) |-> mux_sel_o == CH_TEMP);
  assert_idle_no_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !conv_start_o);
  assert_no_store_at_engine_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start_o |-> !store_we_o);
endmodule

// File: tb/adc_mux_seq_bench.sv
module adc_mux_seq_bench;
  logic clk = 0, rst_n = 0, tick = 0, alt = 0, flen = 0;
  logic [1:0] nsel = 2'd3, cmode = 2'd0;
  logic [2:0] mux_sel;
  logic conv_start, store_we, eng_start, chop;
  logic [7:0] store_addr;

  int vectors = 0, fails = 0;
  bit done = 0;
  // bench model of the cycle position
  int bn = 6, bl = 2, p = 12;
  bit balt = 0, bpend = 0, bchop = 0;

  always #4 clk = ~clk;

  adc_mux_seq u_adc_mux_seq (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .alt_req_i(alt),
    .nsel_i(nsel), .flen_i(flen), .chop_mode_i(cmode),
    .mux_sel_o(mux_sel), .conv_start_o(conv_start), .store_we_o(store_we),
    .store_addr_o(store_addr), .eng_start_o(eng_start), .chop_o(chop)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (n=%0d len=%0d p=%0d alt=%0d)",
               tag, act, exp, bn, bl, p, balt);
    end
  endtask

  function automatic int code(input int st, input bit a);
    if (a && st == 0) return 6;
    if (a && st == 2) return 7;
    return st;
  endfunction

  task automatic do_tick();
    bit s, w;
    @(negedge clk) tick = 1;
    @(negedge clk) tick = 0;
    if (p == bn * bl) begin
      // R10: configuration picked up only here; R9: alternate taken here
      bn = (nsel == 0) ? 2 : (nsel == 1) ? 3 : (nsel == 2) ? 4 : 6;
      bl = flen ? 3 : 2;
      balt = bpend; bpend = 0;
      bchop = (cmode == 0) ? 0 : (cmode == 1) ? 1 : !bchop;
      p = 0;
    end else p++;
    s = (p < bn * bl) && (p % bl == 0);
    w = (p > 0) && (p % bl == 0);
    chk("R4/R8 conv_start", conv_start, s);
    chk("R6 eng_start", eng_start, s && p == 0);
    chk("R4 store_we", store_we, w);
    if (s) chk("R1/R2/R3 mux_sel", mux_sel, code(p / bl, balt));
    if (w) chk("R5 store_addr", store_addr, code(p / bl - 1, balt));
    chk("R7 chop", chop, bchop);
    @(negedge clk);
    chk("R4 pulse width", conv_start | store_we | eng_start, 0);
  endtask

  task automatic pulse_alt();
    @(negedge clk) alt = 1;
    @(negedge clk) alt = 0;
    bpend = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 conv_start", conv_start, 0);
    chk("R11 store_we", store_we, 0);
    chk("R11 eng_start", eng_start, 0);
    chk("R11 chop", chop, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R11 idle after reset", conv_start | store_we, 0);
    for (int ns = 0; ns < 4; ns++)
      for (int fl = 0; fl < 2; fl++)
        for (int cm = 0; cm < 4; cm++) begin
          int ln;
          ln = (ns == 3 ? 6 : ns + 2) * (fl ? 3 : 2) + 1;
          // change configuration mid-cycle (R10)
          do_tick();
          nsel = 2'(ns); flen = fl[0]; cmode = 2'(cm);
          if ((ns + fl + cm) % 2 == 0) pulse_alt(); // R9
          for (int k = 0; k < 3 * ln; k++) begin
            do_tick();
            if (k == ln + 1 && cm == 3) pulse_alt();
          end
        end
    // back-to-back alternate requests on the 13-tick cycle (R8, R9)
    nsel = 2'd3; flen = 0; cmode = 2'd2;
    for (int k = 0; k < 60; k++) begin
      if (k % 7 == 3) pulse_alt();
      do_tick();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule